// File: doc/BRIEF.md
# Big-Endian Load/Store Alignment Unit

This unit sits between the execute stage of a 32-bit core and a byte-addressed, big-endian data memory. For each accepted operation it adds the base register to the sign-extended 16-bit offset to form the effective address. It decodes the 6-bit operation code into a load, a store, the load-upper-immediate operation, or an illegal code. It then checks natural alignment for the access size. A legal memory operation produces a word-aligned request with byte enables. On a store, the request also carries the write data steered into the correct byte lanes. Returned read data is lane-extracted, sign- or zero-extended and registered for writeback.

All three data flows use valid/ready handshakes. The unit handles one operation at a time. `req_ready` is high only when the unit is idle. A memory request holds `mem_valid` and all of its fields steady until `mem_ready` is seen. A writeback holds `wb_valid`, `wb_data` and `wb_tag` steady until `wb_ready` is seen. Read data has no back-pressure: a single `rd_valid` pulse delivers it, and the unit takes it only while a load is waiting. The two fault flags are plain one-cycle pulses.

Top module: `lsu_be_align`

## Requirements
- R1: The effective address is `req_base` plus `req_offset` sign-extended to 32 bits, modulo 2^32. `mem_addr` carries this address with bits [1:0] cleared.
- R2: These codes are loads and issue a read request (`mem_write`=0): 0x20 signed byte, 0x21 signed halfword, 0x23 word, 0x24 unsigned byte, 0x25 unsigned halfword.
- R3: These codes are stores and issue a write request (`mem_write`=1) with no writeback: 0x28 byte, 0x29 halfword, 0x2B word. Unaddressed lanes of `mem_wdata` are zero.
- R4: Big-endian lanes: the byte at address offset k (k = address bits [1:0]) maps to `mem_be` bit 3-k and to data bits [31-8k:24-8k]. Only the addressed lanes are enabled. A byte access enables one lane, a halfword two, a word all four.
- R5: A halfword access with address bit 0 set, or a word access with address bits [1:0] not both zero, pulses `fault_addr` for one cycle right after acceptance. It issues no memory request and no writeback.
- R6: Code 0x0F writes back the offset field shifted left by 16 with the low half zero, and issues no memory request.
- R7: Any other code pulses `fault_instr` for one cycle right after acceptance, with no memory request and no writeback.
- R8: Signed byte and halfword loads sign-extend to 32 bits. The unsigned forms zero-extend. A halfword at offset 0 takes bytes 0,1, and at offset 2 takes bytes 2,3, with the lower address as the upper byte.
- R9: A load result appears on `wb_valid`/`wb_data` one cycle after the clock edge that samples `rd_valid`, and not before.
- R10: `req_ready` is high only when idle. An unaccepted memory request and an unaccepted writeback each hold steady until their ready is seen.
- R11: After reset, `req_ready` is 1 and `mem_valid`, `wb_valid`, `fault_addr` and `fault_instr` are 0.
- R12: `wb_tag` returns the `req_tag` of the operation it belongs to.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Operation offered |
| req_ready | output | 1 | Unit idle, operation will be accepted |
| req_opcode | input | 6 | Operation code |
| req_base | input | 32 | Base register value |
| req_offset | input | 16 | Immediate offset / upper-immediate value |
| req_wdata | input | 32 | Store source register value |
| req_tag | input | TAG_W | Destination tag returned with writeback |
| mem_valid | output | 1 | Memory request valid |
| mem_ready | input | 1 | Memory accepts request |
| mem_write | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Word-aligned address |
| mem_be | output | 4 | Byte enables, bit 3 = lowest address |
| mem_wdata | output | 32 | Lane-placed store data |
| rd_valid | input | 1 | Read data returned |
| rd_data | input | 32 | Read word, bits 31:24 = lowest address |
| wb_valid | output | 1 | Writeback valid |
| wb_ready | input | 1 | Writeback accepted |
| wb_data | output | 32 | Writeback value |
| wb_tag | output | TAG_W | Writeback tag |
| fault_addr | output | 1 | Misaligned access pulse |
| fault_instr | output | 1 | Illegal code pulse |

## Verification
The request is accepted at one clock edge. Straight after that edge, a fault pulse, a memory request or an upper-immediate writeback is already visible. The fault pulse is gone one cycle later. A load result follows one cycle after the edge that samples `rd_valid`. The bench drives and samples on the falling clock edge and checks every output in the first half-cycle after the edge where it is due. It also checks for absence one cycle earlier: no writeback before read data arrives, and no fault pulse a cycle late. Back-pressure stalls of random length check that the held values stay steady, and a bench model of memory with a big-endian byte view supplies the expected lanes and extensions.

// File: rtl/lsu_be_pkg.sv
package lsu_be_pkg;

  localparam int unsigned LSU_DATA_W = 32;
  localparam int unsigned LSU_LANES  = LSU_DATA_W / 8;
  localparam int unsigned LSU_OPC_W  = 6;

  localparam logic [LSU_OPC_W-1:0] OPC_LD_B  = 6'h20;
  localparam logic [LSU_OPC_W-1:0] OPC_LD_H  = 6'h21;
  localparam logic [LSU_OPC_W-1:0] OPC_LD_W  = 6'h23;
  localparam logic [LSU_OPC_W-1:0] OPC_LD_BU = 6'h24;
  localparam logic [LSU_OPC_W-1:0] OPC_LD_HU = 6'h25;
  localparam logic [LSU_OPC_W-1:0] OPC_ST_B  = 6'h28;
  localparam logic [LSU_OPC_W-1:0] OPC_ST_H  = 6'h29;
  localparam logic [LSU_OPC_W-1:0] OPC_ST_W  = 6'h2B;
  localparam logic [LSU_OPC_W-1:0] OPC_UPPER = 6'h0F;

  typedef enum logic [1:0] {
    KIND_LOAD, KIND_STORE, KIND_UPPER, KIND_ILLEGAL
  } op_kind_t;

  typedef enum logic [1:0] {
    SIZE_BYTE, SIZE_HALF, SIZE_WORD
  } acc_size_t;

  typedef struct packed {
    op_kind_t  kind;
    acc_size_t size;
    logic      sext;
  } op_dec_t;

  typedef enum logic [1:0] {
    ST_IDLE, ST_ISSUE, ST_WAIT, ST_RESP
  } lsu_state_t;

endpackage

// File: rtl/lsu_decode.sv
module lsu_decode
  import lsu_be_pkg::*;
(
  input  logic [LSU_OPC_W-1:0] opcode,
  output op_dec_t              dec
);

  always_comb begin
    dec.kind = KIND_ILLEGAL;
    dec.size = SIZE_WORD;
    dec.sext = 1'b0;
    unique case (opcode)
      OPC_LD_B:  begin dec.kind = KIND_LOAD;  dec.size = SIZE_BYTE; dec.sext = 1'b1; end
      OPC_LD_BU: begin dec.kind = KIND_LOAD;  dec.size = SIZE_BYTE; end
      OPC_LD_H:  begin dec.kind = KIND_LOAD;  dec.size = SIZE_HALF; dec.sext = 1'b1; end
      OPC_LD_HU: begin dec.kind = KIND_LOAD;  dec.size = SIZE_HALF; end
      OPC_LD_W:  begin dec.kind = KIND_LOAD;  dec.size = SIZE_WORD; end
      OPC_ST_B:  begin dec.kind = KIND_STORE; dec.size = SIZE_BYTE; end
      OPC_ST_H:  begin dec.kind = KIND_STORE; dec.size = SIZE_HALF; end
      OPC_ST_W:  begin dec.kind = KIND_STORE; dec.size = SIZE_WORD; end
      OPC_UPPER: begin dec.kind = KIND_UPPER; end
      default:   begin dec.kind = KIND_ILLEGAL; end
    endcase
  end

endmodule

// File: rtl/lsu_lane_steer.sv
module lsu_lane_steer
  import lsu_be_pkg::*;
(
  input  acc_size_t               size,
  input  logic [1:0]              lo_addr,
  input  logic [LSU_DATA_W-1:0]   src,
  output logic [LSU_LANES-1:0]    be,
  output logic [LSU_DATA_W-1:0]   lanes,
  output logic                    misaligned
);

  always_comb begin
    unique case (size)
      SIZE_HALF: misaligned = lo_addr[0];
      SIZE_WORD: misaligned = |lo_addr;
      default:   misaligned = 1'b0;
    endcase
  end

  // Lane i holds the byte at address offset i (big-endian numbering).
  for (genvar i = 0; i < LSU_LANES; i++) begin : g_lane
    localparam int          HI = LSU_DATA_W - 1 - 8 * i;
    localparam logic [1:0]  LN = 2'(i);
    logic       sel;
    logic [7:0] lane_byte;

    always_comb begin
      unique case (size)
        SIZE_BYTE: begin
          sel       = (lo_addr == LN);
          lane_byte = src[7:0];
        end
        SIZE_HALF: begin
          sel       = (lo_addr[1] == LN[1]);
          lane_byte = LN[0] ? src[7:0] : src[15:8];
        end
        default: begin
          sel       = 1'b1;
          lane_byte = src[HI -: 8];
        end
      endcase
    end

    assign be[LSU_LANES-1-i] = sel;
    assign lanes[HI -: 8]    = sel ? lane_byte : 8'h00;
  end

endmodule

// File: rtl/lsu_load_extract.sv
module lsu_load_extract
  import lsu_be_pkg::*;
(
  input  logic [LSU_DATA_W-1:0] rdata,
  input  logic [1:0]            lo_addr,
  input  acc_size_t             size,
  input  logic                  sext,
  output logic [LSU_DATA_W-1:0] result
);

  logic [7:0]  pick_b;
  logic [15:0] pick_h;

  always_comb begin
    unique case (lo_addr)
      2'd0:    pick_b = rdata[31:24];
      2'd1:    pick_b = rdata[23:16];
      2'd2:    pick_b = rdata[15:8];
      default: pick_b = rdata[7:0];
    endcase
    pick_h = lo_addr[1] ? rdata[15:0] : rdata[31:16];
  end

  always_comb begin
    unique case (size)
      SIZE_BYTE: result = {{(LSU_DATA_W-8){sext & pick_b[7]}}, pick_b};
      SIZE_HALF: result = {{(LSU_DATA_W-16){sext & pick_h[15]}}, pick_h};
      default:   result = rdata;
    endcase
  end

endmodule

// File: rtl/lsu_be_align.sv
module lsu_be_align
  import lsu_be_pkg::*;
#(
  parameter int unsigned TAG_W = 5,
  parameter int unsigned IMM_W = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic [LSU_OPC_W-1:0]  req_opcode,
  input  logic [LSU_DATA_W-1:0] req_base,
  input  logic [IMM_W-1:0]      req_offset,
  input  logic [LSU_DATA_W-1:0] req_wdata,
  input  logic [TAG_W-1:0]      req_tag,
  output logic                  mem_valid,
  input  logic                  mem_ready,
  output logic                  mem_write,
  output logic [LSU_DATA_W-1:0] mem_addr,
  output logic [LSU_LANES-1:0]  mem_be,
  output logic [LSU_DATA_W-1:0] mem_wdata,
  input  logic                  rd_valid,
  input  logic [LSU_DATA_W-1:0] rd_data,
  output logic                  wb_valid,
  input  logic                  wb_ready,
  output logic [LSU_DATA_W-1:0] wb_data,
  output logic [TAG_W-1:0]      wb_tag,
  output logic                  fault_addr,
  output logic                  fault_instr
);

  localparam int unsigned UPPER_PAD = LSU_DATA_W - IMM_W;

  lsu_state_t            state_q;
  op_dec_t               dec;
  logic [LSU_DATA_W-1:0] ea;
  logic [LSU_LANES-1:0]  be_c;
  logic [LSU_DATA_W-1:0] lanes_c;
  logic                  misaligned_c;
  logic                  accept;

  logic [1:0]            lo_q;
  acc_size_t             size_q;
  logic                  sext_q;
  logic [LSU_DATA_W-1:0] load_c;

  assign ea     = req_base + {{UPPER_PAD{req_offset[IMM_W-1]}}, req_offset};
  assign accept = req_valid && (state_q == ST_IDLE);

  lsu_decode u_decode (
    .opcode (req_opcode),
    .dec    (dec)
  );

  lsu_lane_steer u_steer (
    .size       (dec.size),
    .lo_addr    (ea[1:0]),
    .src        (req_wdata),
    .be         (be_c),
    .lanes      (lanes_c),
    .misaligned (misaligned_c)
  );

  lsu_load_extract u_extract (
    .rdata   (rd_data),
    .lo_addr (lo_q),
    .size    (size_q),
    .sext    (sext_q),
    .result  (load_c)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      fault_addr  <= 1'b0;
      fault_instr <= 1'b0;
      mem_write   <= 1'b0;
      mem_addr    <= '0;
      mem_be      <= '0;
      mem_wdata   <= '0;
      wb_data     <= '0;
      wb_tag      <= '0;
      lo_q        <= '0;
      size_q      <= SIZE_WORD;
      sext_q      <= 1'b0;
    end else begin
      fault_addr  <= 1'b0;
      fault_instr <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (accept) begin
            wb_tag    <= req_tag;
            lo_q      <= ea[1:0];
            size_q    <= dec.size;
            sext_q    <= dec.sext;
            mem_addr  <= {ea[LSU_DATA_W-1:2], 2'b00};
            mem_be    <= be_c;
            mem_write <= (dec.kind == KIND_STORE);
            mem_wdata <= (dec.kind == KIND_STORE) ? lanes_c : '0;
            unique case (dec.kind)
              KIND_ILLEGAL: fault_instr <= 1'b1;
              KIND_UPPER: begin
                wb_data <= {req_offset, {UPPER_PAD{1'b0}}};
                state_q <= ST_RESP;
              end
              default: begin
                if (misaligned_c) fault_addr <= 1'b1;
                else              state_q    <= ST_ISSUE;
              end
            endcase
          end
        end
        ST_ISSUE: begin
          if (mem_ready) state_q <= mem_write ? ST_IDLE : ST_WAIT;
        end
        ST_WAIT: begin
          if (rd_valid) begin
            wb_data <= load_c;
            state_q <= ST_RESP;
          end
        end
        default: begin
          if (wb_ready) state_q <= ST_IDLE;
        end
      endcase
    end
  end

  assign req_ready = (state_q == ST_IDLE);
  assign mem_valid = (state_q == ST_ISSUE);
  assign wb_valid  = (state_q == ST_RESP);

endmodule

// File: rtl/lsu_be_align_chk.sv
module lsu_be_align_chk
  import lsu_be_pkg::*;
#(
  parameter int unsigned TAG_W = 5
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  req_ready,
  input logic                  mem_valid,
  input logic                  mem_ready,
  input logic                  mem_write,
  input logic [LSU_DATA_W-1:0] mem_addr,
  input logic [LSU_LANES-1:0]  mem_be,
  input logic [LSU_DATA_W-1:0] mem_wdata,
  input logic                  wb_valid,
  input logic                  wb_ready,
  input logic [LSU_DATA_W-1:0] wb_data,
  input logic [TAG_W-1:0]      wb_tag,
  input logic                  fault_addr,
  input logic                  fault_instr
);

  function automatic logic [LSU_DATA_W-1:0] lane_mask(input logic [LSU_LANES-1:0] be);
    logic [LSU_DATA_W-1:0] m;
    for (int i = 0; i < LSU_LANES; i++) m[8*i +: 8] = {8{be[i]}};
    return m;
  endfunction

  p_mem_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_be)
                                && $stable(mem_wdata) && $stable(mem_write));

  p_wb_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid && !wb_ready |=> wb_valid && $stable(wb_data) && $stable(wb_tag));

  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !mem_valid && !wb_valid);

  p_fault_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fault_addr |-> !mem_valid && !wb_valid);

  p_fault_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fault_instr |-> !mem_valid && !wb_valid && !fault_addr);

  p_fault_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fault_addr |=> !fault_addr);

  p_be_shape_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> (mem_be == 4'b1000 || mem_be == 4'b0100 || mem_be == 4'b0010 ||
                   mem_be == 4'b0001 || mem_be == 4'b1100 || mem_be == 4'b0011 ||
                   mem_be == 4'b1111));

  p_lane_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && mem_write |-> (mem_wdata & ~lane_mask(mem_be)) == '0);

  p_addr_aligned_r1: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> mem_addr[1:0] == 2'b00);

endmodule

bind lsu_be_align lsu_be_align_chk #(.TAG_W(TAG_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_ready   (req_ready),
  .mem_valid   (mem_valid),
  .mem_ready   (mem_ready),
  .mem_write   (mem_write),
  .mem_addr    (mem_addr),
  .mem_be      (mem_be),
  .mem_wdata   (mem_wdata),
  .wb_valid    (wb_valid),
  .wb_ready    (wb_ready),
  .wb_data     (wb_data),
  .wb_tag      (wb_tag),
  .fault_addr  (fault_addr),
  .fault_instr (fault_instr)
);

// File: tb/test_lsu_be_align.sv
`timescale 1ns/1ps
module test_lsu_be_align;

  localparam int TAG_W = 5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [5:0]  req_opcode = '0;
  logic [31:0] req_base = '0;
  logic [15:0] req_offset = '0;
  logic [31:0] req_wdata = '0;
  logic [TAG_W-1:0] req_tag = '0;
  logic        mem_valid, mem_write;
  logic        mem_ready = 1'b0;
  logic [31:0] mem_addr, mem_wdata;
  logic [3:0]  mem_be;
  logic        rd_valid = 1'b0;
  logic [31:0] rd_data = '0;
  logic        wb_valid;
  logic        wb_ready = 1'b0;
  logic [31:0] wb_data;
  logic [TAG_W-1:0] wb_tag;
  logic        fault_addr, fault_instr;

  int unsigned checks = 0;
  int unsigned failures = 0;
  logic [31:0] model [16];

  always #2 clk = ~clk;

  lsu_be_align #(.TAG_W(TAG_W)) i_lsu_be_align (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_opcode(req_opcode),
    .req_base(req_base), .req_offset(req_offset), .req_wdata(req_wdata), .req_tag(req_tag),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_write(mem_write),
    .mem_addr(mem_addr), .mem_be(mem_be), .mem_wdata(mem_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data),
    .wb_valid(wb_valid), .wb_ready(wb_ready), .wb_data(wb_data), .wb_tag(wb_tag),
    .fault_addr(fault_addr), .fault_instr(fault_instr)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  // 0 load, 1 store, 2 upper, 3 illegal
  function automatic int kind_of(input logic [5:0] op);
    case (op)
      6'h20, 6'h21, 6'h23, 6'h24, 6'h25: return 0;
      6'h28, 6'h29, 6'h2B:               return 1;
      6'h0F:                             return 2;
      default:                           return 3;
    endcase
  endfunction

  function automatic int bytes_of(input logic [5:0] op);
    case (op)
      6'h20, 6'h24, 6'h28: return 1;
      6'h21, 6'h25, 6'h29: return 2;
      default:             return 4;
    endcase
  endfunction

  function automatic logic [3:0] exp_be(input int n, input logic [1:0] lo);
    logic [3:0] b = '0;
    for (int k = 0; k < 4; k++)
      if (k >= lo && k < lo + n) b[3-k] = 1'b1;
    return b;
  endfunction

  function automatic logic [31:0] exp_lanes(input int n, input logic [1:0] lo, input logic [31:0] sd);
    logic [31:0] w = '0;
    for (int j = 0; j < n; j++)
      w[31-8*(lo+j) -: 8] = sd[8*(n-1-j) +: 8];
    return w;
  endfunction

  function automatic logic [31:0] exp_load(input logic [5:0] op, input logic [1:0] lo, input logic [31:0] w);
    logic [7:0]  b = w[31-8*lo -: 8];
    logic [15:0] h = {w[31-8*lo -: 8], w[23-8*lo -: 8]};
    case (op)
      6'h20: return {{24{b[7]}}, b};
      6'h24: return {24'h0, b};
      6'h21: return {{16{h[15]}}, h};
      6'h25: return {16'h0, h};
      default: return w;
    endcase
  endfunction

  task automatic drain_wb(input logic [31:0] exp, input logic [TAG_W-1:0] tag, input string req);
    int stall = $urandom % 3;
    chk(wb_valid == 1'b1, "R9 wb_valid", 32'(wb_valid), 32'd1);
    chk(wb_data == exp, req, wb_data, exp);
    chk(wb_tag == tag, "R12 tag", 32'(wb_tag), 32'(tag));
    for (int s = 0; s < stall; s++) begin
      @(negedge clk);
      chk(wb_valid && wb_data == exp, "R10 wb hold", wb_data, exp);
    end
    wb_ready = 1'b1;
    @(negedge clk);
    wb_ready = 1'b0;
    chk(!wb_valid && req_ready, "R10 wb release", 32'(wb_valid), 32'd0);
  endtask

  task automatic run_op(input logic [5:0] op, input logic [31:0] base, input logic [15:0] off, input logic [31:0] sd);
    logic [31:0] ea = base + {{16{off[15]}}, off};
    logic [1:0]  lo = ea[1:0];
    int          k  = kind_of(op);
    int          n  = bytes_of(op);
    logic [TAG_W-1:0] tag = TAG_W'($urandom);
    bit          mis = (n == 2 && lo[0]) || (n == 4 && lo != 2'b00);
    @(negedge clk);
    chk(req_ready == 1'b1, "R10 ready idle", 32'(req_ready), 32'd1);
    req_valid = 1'b1; req_opcode = op; req_base = base; req_offset = off;
    req_wdata = sd; req_tag = tag;
    @(negedge clk);
    req_valid = 1'b0;
    if (k == 3) begin
      chk(fault_instr && !mem_valid && !wb_valid, "R7 illegal", 32'(fault_instr), 32'd1);
      @(negedge clk);
      chk(!fault_instr && !mem_valid && !wb_valid, "R7 pulse", 32'(fault_instr), 32'd0);
    end else if (k == 2) begin
      chk(!mem_valid && !fault_addr, "R6 no mem", 32'(mem_valid), 32'd0);
      drain_wb({off, 16'h0}, tag, "R6 upper");
    end else if (mis) begin
      chk(fault_addr && !mem_valid && !wb_valid, "R5 misaligned", 32'(fault_addr), 32'd1);
      @(negedge clk);
      chk(!fault_addr && !mem_valid && !wb_valid, "R5 pulse", 32'(fault_addr), 32'd0);
    end else begin
      int stall = $urandom % 3;
      chk(mem_valid == 1'b1, "R2 R3 request", 32'(mem_valid), 32'd1);
      chk(mem_addr == {ea[31:2], 2'b00}, "R1 address", mem_addr, {ea[31:2], 2'b00});
      chk(mem_be == exp_be(n, lo), "R4 byte enables", 32'(mem_be), 32'(exp_be(n, lo)));
      chk(mem_write == (k == 1), "R2 R3 direction", 32'(mem_write), 32'(k == 1));
      chk(!req_ready, "R10 busy", 32'(req_ready), 32'd0);
      if (k == 1)
        chk(mem_wdata == exp_lanes(n, lo, sd), "R3 R4 store lanes", mem_wdata, exp_lanes(n, lo, sd));
      for (int s = 0; s < stall; s++) begin
        @(negedge clk);
        chk(mem_valid && mem_addr == {ea[31:2], 2'b00}, "R10 mem hold", mem_addr, {ea[31:2], 2'b00});
      end
      mem_ready = 1'b1;
      @(negedge clk);
      mem_ready = 1'b0;
      if (k == 1) begin
        for (int b = 0; b < 4; b++)
          if (exp_be(n, lo)[3-b]) model[ea[5:2]][31-8*b -: 8] = exp_lanes(n, lo, sd)[31-8*b -: 8];
        chk(req_ready && !wb_valid && !mem_valid, "R3 no writeback", 32'(wb_valid), 32'd0);
      end else begin
        int dly = $urandom % 3;
        logic [31:0] exp = exp_load(op, lo, model[ea[5:2]]);
        for (int s = 0; s < dly; s++) @(negedge clk);
        chk(!wb_valid && !mem_valid, "R9 early", 32'(wb_valid), 32'd0);
        rd_valid = 1'b1; rd_data = model[ea[5:2]];
        @(negedge clk);
        rd_valid = 1'b0; rd_data = $urandom;
        drain_wb(exp, tag, "R8 R2 load value");
      end
    end
  endtask

  initial begin
    for (int c = 0; c < 150000; c++) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=%08h expected=%08h", 32'd0, 32'd1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [5:0] ops [13] = '{6'h20, 6'h21, 6'h23, 6'h24, 6'h25, 6'h28, 6'h29, 6'h2B,
                             6'h0F, 6'h22, 6'h26, 6'h00, 6'h3F};
    void'($urandom(32'd20240611));
    for (int i = 0; i < 16; i++) model[i] = $urandom;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk(req_ready && !mem_valid && !wb_valid && !fault_addr && !fault_instr,
        "R11 reset", 32'(req_ready), 32'd1);

    // directed corners
    model[4] = 32'h80FF_7F01;
    run_op(6'h20, 32'h10, 16'h0000, 0);     // R8 lb 0x80 -> negative
    run_op(6'h24, 32'h10, 16'h0000, 0);     // R8 lbu zero-extend
    run_op(6'h21, 32'h12, 16'h0000, 0);     // R8 lh offset 2 -> 7F01
    run_op(6'h21, 32'h10, 16'h0000, 0);     // R8 lh offset 0 -> 80FF negative
    run_op(6'h25, 32'h10, 16'h0000, 0);     // R8 lhu
    run_op(6'h23, 32'h14, 16'hFFFC, 0);     // R1 negative offset
    run_op(6'h23, 32'hFFFF_FFF0, 16'h0020, 0); // R1 wraparound
    run_op(6'h21, 32'h11, 16'h0000, 0);     // R5 half odd
    run_op(6'h23, 32'h12, 16'h0000, 0);     // R5 word offset 2
    run_op(6'h2B, 32'h13, 16'h0000, 32'h1234_5678); // R5 store word misaligned
    run_op(6'h28, 32'h21, 16'h0000, 32'hAABB_CCDD); // R4 byte lane 1
    run_op(6'h29, 32'h22, 16'h0000, 32'h1122_3344); // R4 half low lanes
    run_op(6'h2B, 32'h24, 16'h0000, 32'hCAFE_F00D); // R3 word
    run_op(6'h0F, 32'h0, 16'hBEEF, 0);      // R6 upper
    run_op(6'h22, 32'h0, 16'h0000, 0);      // R7 illegal
    run_op(6'h20, 32'h21, 16'h0000, 0);     // R2 readback of stored byte

    // constrained random mix
    for (int i = 0; i < 400; i++) begin
      logic [5:0] op = ops[$urandom % 13];
      logic [31:0] base = $urandom;
      logic [15:0] off = 16'($urandom);
      if (($urandom % 4) != 0) base[1:0] = 2'b00;
      if (($urandom % 2) != 0) off[1:0] = 2'b00;
      run_op(op, base, off, $urandom);
    end

    repeat (2) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule